// File: doc/BRIEF.md
# UART Control Decoder and Channel Mode Router

This block holds the control and channel-mode settings of a UART and uses them to steer character traffic. Host writes to the control word set the receiver and transmitter enables and the break request, and fire one-cycle strobes for receiver reset, transmitter reset and receive-timeout restart. A separate host write selects one of four channel modes. Serial framing, baud timing and FIFO storage belong to neighbouring blocks.

Two character sources feed the router: characters that arrive from the serial line, and host writes to the data port. Two sinks leave it: the receive FIFO and the transmitter. Every source and sink is a valid/ready stream. A character moves when valid and ready are both high on the same rising edge. A character routed to a disabled path, or to no sink in the current mode, is taken at once (ready high) and dropped. A character routed to live sinks waits until each of those sinks is ready. In echo mode a line character goes to both sinks. Each sink then sees valid only while the other sink is also ready, so the character is pushed to both sinks on the same edge or to neither.

Top module: `uart_ctl_router`

## Requirements
- R1: After reset the control word is 0x128. Receive disable (bit 3), transmit disable (bit 5) and stop break (bit 8) are set, so both paths are off, brk_o is low, all strobes are low and the channel mode is normal.
- R2: The receive path is on only while receive enable (bit 2) is 1 and receive disable (bit 3) is 0. The transmit path is on only while transmit enable (bit 4) is 1 and transmit disable (bit 5) is 0. A set disable bit wins over a set enable bit.
- R3: A control write with bit 0 set drives rx_rst_o high for exactly the one cycle after the write. Bit 1 does the same on tx_rst_o. Neither bit is kept, so later control writes without these bits give no pulse.
- R4: A control write with bit 6 set drives to_restart_o high for exactly the one cycle after the write, and the bit is not kept.
- R5: brk_o is high exactly while the stored start break bit (bit 7) is 1 and stop break (bit 8) is 0. It changes only after a control write.
- R6: A mode write (cfg_sel=1) takes the channel mode from cfg_wdata[9:8]: 0 normal, 1 echo, 2 local loopback, 3 remote loopback.
- R7: Normal mode: line characters go to the receive FIFO and host characters go to the transmitter.
- R8: Echo mode: a line character goes to both the receive FIFO and the transmitter, and is accepted only when both accept it. Host characters are dropped.
- R9: Local loopback: host characters go to the receive FIFO, line characters are dropped, and the transmitter sees no valid.
- R10: Remote loopback: line characters go to the transmitter, host characters are dropped, and the receive FIFO sees no valid.
- R11: A character whose target path is off is dropped. Its source sees ready high and the sink sees no valid.
- R12: A routed character reaches its sink unchanged. The source's ready follows the sink's ready, and the sink's valid stays high while the source holds valid.
- R13: A configuration write takes effect from the cycle after its clock edge. Traffic in the cycle of the write is routed with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the mode word |
| cfg_wdata | input | 10 | Write data (control uses bits 8:0, mode uses bits 9:8) |
| line_valid | input | 1 | Character from the serial line is valid |
| line_data | input | DATA_W | Line character |
| line_ready | output | 1 | Line character accepted |
| host_valid | input | 1 | Host data-port write is valid |
| host_data | input | DATA_W | Host character |
| host_ready | output | 1 | Host character accepted |
| rxq_valid | output | 1 | Push into the receive FIFO |
| rxq_data | output | DATA_W | Character for the receive FIFO |
| rxq_ready | input | 1 | Receive FIFO can take a character |
| txq_valid | output | 1 | Push to the transmitter |
| txq_data | output | DATA_W | Character for the transmitter |
| txq_ready | input | 1 | Transmitter can take a character |
| rx_rst_o | output | 1 | One-cycle receiver reset strobe |
| tx_rst_o | output | 1 | One-cycle transmitter reset strobe |
| to_restart_o | output | 1 | One-cycle receive-timeout restart strobe |
| brk_o | output | 1 | Break request level |

## Verification
A configuration write and a character push can land on the same clock edge. The concern is whether the push is judged against the old or the new enables and mode. The bench holds a line character valid while it writes a control word that disables the receive path. In the write cycle the character must still reach the receive FIFO. From the next cycle it must be dropped with ready high. A mode write made while a host character is waiting is checked the same way: the character follows the old route in the write cycle and the new route afterwards.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  typedef enum logic [1:0] {
    CHM_NORMAL = 2'd0,
    CHM_ECHO   = 2'd1,
    CHM_LOCAL  = 2'd2,
    CHM_REMOTE = 2'd3
  } chan_mode_e;

  // control word bit positions
  localparam int CB_RX_RST   = 0;
  localparam int CB_TX_RST   = 1;
  localparam int CB_RX_ON    = 2;
  localparam int CB_RX_OFF   = 3;
  localparam int CB_TX_ON    = 4;
  localparam int CB_TX_OFF   = 5;
  localparam int CB_TO_RST   = 6;
  localparam int CB_BRK_GO   = 7;
  localparam int CB_BRK_HALT = 8;
  localparam int CTRL_W      = 9;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;

  // mode word: channel mode field position
  localparam int MODE_LSB = 8;
  localparam int CFG_W    = MODE_LSB + 2;

  // self-clearing command bits, one strobe each
  localparam int N_STB = 3;
  localparam int STB_BIT [N_STB] = '{CB_RX_RST, CB_TX_RST, CB_TO_RST};
endpackage

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
  import uart_ctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic                   rx_en,
  output logic                   tx_en,
  output logic                   brk_o,
  output chan_mode_e             chan_mode,
  output logic [N_STB-1:0]       stb_o
);
  logic ctrl_wr, mode_wr;
  assign ctrl_wr = cfg_we && !cfg_sel;
  assign mode_wr = cfg_we &&  cfg_sel;

  // stored (non self-clearing) control bits
  logic rx_on_q, rx_off_q, tx_on_q, tx_off_q, brk_go_q, brk_halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on_q    <= CTRL_RESET[CB_RX_ON];
      rx_off_q   <= CTRL_RESET[CB_RX_OFF];
      tx_on_q    <= CTRL_RESET[CB_TX_ON];
      tx_off_q   <= CTRL_RESET[CB_TX_OFF];
      brk_go_q   <= CTRL_RESET[CB_BRK_GO];
      brk_halt_q <= CTRL_RESET[CB_BRK_HALT];
    end else if (ctrl_wr) begin
      rx_on_q    <= cfg_wdata[CB_RX_ON];
      rx_off_q   <= cfg_wdata[CB_RX_OFF];
      tx_on_q    <= cfg_wdata[CB_TX_ON];
      tx_off_q   <= cfg_wdata[CB_TX_OFF];
      brk_go_q   <= cfg_wdata[CB_BRK_GO];
      brk_halt_q <= cfg_wdata[CB_BRK_HALT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chan_mode <= CHM_NORMAL;
    else if (mode_wr) chan_mode <= chan_mode_e'(cfg_wdata[MODE_LSB +: 2]);
  end

  // one flop per command bit: high for the cycle after the write only
  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_o[g] <= 1'b0;
      else        stb_o[g] <= ctrl_wr && cfg_wdata[STB_BIT[g]];
    end
  end

  // disable dominates enable
  assign rx_en = rx_on_q && !rx_off_q;
  assign tx_en = tx_on_q && !tx_off_q;
  assign brk_o = brk_go_q && !brk_halt_q;
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  chan_mode_e        chan_mode,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  output logic              line_ready,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_data,
  output logic              host_ready,
  output logic              rxq_valid,
  output logic [DATA_W-1:0] rxq_data,
  input  logic              rxq_ready,
  output logic              txq_valid,
  output logic [DATA_W-1:0] txq_data,
  input  logic              txq_ready
);
  logic line_to_rx, line_to_tx, host_to_rx, host_to_tx;

  always_comb begin
    line_to_rx = 1'b0;
    line_to_tx = 1'b0;
    host_to_rx = 1'b0;
    host_to_tx = 1'b0;
    unique case (chan_mode)
      CHM_NORMAL: begin line_to_rx = rx_en; host_to_tx = tx_en; end
      CHM_ECHO:   begin line_to_rx = rx_en; line_to_tx = tx_en; end
      CHM_LOCAL:  host_to_rx = rx_en;
      CHM_REMOTE: line_to_tx = tx_en;
      default: ;
    endcase
  end

  // joint acceptance when a line character fans out to both sinks
  logic line_rx_go, line_tx_go;
  assign line_rx_go = !line_to_tx || txq_ready;
  assign line_tx_go = !line_to_rx || rxq_ready;

  always_comb begin
    if (host_to_rx) begin
      rxq_valid = host_valid;
      rxq_data  = host_data;
    end else begin
      rxq_valid = line_valid && line_to_rx && line_rx_go;
      rxq_data  = line_data;
    end
    if (host_to_tx) begin
      txq_valid = host_valid;
      txq_data  = host_data;
    end else begin
      txq_valid = line_valid && line_to_tx && line_tx_go;
      txq_data  = line_data;
    end
  end

  // unrouted or disabled traffic is consumed at once
  assign line_ready = (!line_to_rx || rxq_ready) && (!line_to_tx || txq_ready);
  assign host_ready = (!host_to_rx || rxq_ready) && (!host_to_tx || txq_ready);
endmodule

// File: rtl/uart_ctl_router.sv
module uart_ctl_router
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  output logic              line_ready,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_data,
  output logic              host_ready,
  output logic              rxq_valid,
  output logic [DATA_W-1:0] rxq_data,
  input  logic              rxq_ready,
  output logic              txq_valid,
  output logic [DATA_W-1:0] txq_data,
  input  logic              txq_ready,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              to_restart_o,
  output logic              brk_o
);
  logic             rx_en, tx_en;
  chan_mode_e       chan_mode;
  logic [N_STB-1:0] stb;

  uart_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .brk_o     (brk_o),
    .chan_mode (chan_mode),
    .stb_o     (stb)
  );

  assign rx_rst_o     = stb[0];
  assign tx_rst_o     = stb[1];
  assign to_restart_o = stb[2];

  uart_chan_router #(.DATA_W(DATA_W)) u_route (
    .chan_mode  (chan_mode),
    .rx_en      (rx_en),
    .tx_en      (tx_en),
    .line_valid (line_valid),
    .line_data  (line_data),
    .line_ready (line_ready),
    .host_valid (host_valid),
    .host_data  (host_data),
    .host_ready (host_ready),
    .rxq_valid  (rxq_valid),
    .rxq_data   (rxq_data),
    .rxq_ready  (rxq_ready),
    .txq_valid  (txq_valid),
    .txq_data   (txq_data),
    .txq_ready  (txq_ready)
  );
endmodule

// File: rtl/uart_ctl_router_chk.sv
module uart_ctl_router_chk
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic              rx_en,
  input logic              tx_en,
  input chan_mode_e        chan_mode,
  input logic              line_data_eq,
  input logic              rxq_valid,
  input logic              txq_valid,
  input logic              host_ready,
  input logic              rx_rst_o,
  input logic              tx_rst_o,
  input logic              to_restart_o,
  input logic              brk_o
);
  // R3
  rx_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_o |=> !rx_rst_o);
  // R3
  rx_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_o |-> $past(cfg_we && !cfg_sel && cfg_wdata[CB_RX_RST]));
  // R3
  tx_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_o |=> !tx_rst_o);
  // R4
  to_restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_restart_o |=> !to_restart_o);
  // R5
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we && !cfg_sel) |-> $stable(brk_o));
  // R8
  echo_host_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == CHM_ECHO) |-> host_ready);
  // R9
  local_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == CHM_LOCAL) |-> !txq_valid);
  // R10
  remote_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == CHM_REMOTE) |-> !rxq_valid);
  // R11
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rxq_valid);
  // R11
  tx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !txq_valid);
  // R12
  rx_data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_valid && chan_mode != CHM_LOCAL) |-> line_data_eq);
endmodule

bind uart_ctl_router uart_ctl_router_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_wdata    (cfg_wdata),
  .rx_en        (rx_en),
  .tx_en        (tx_en),
  .chan_mode    (chan_mode),
  .line_data_eq (rxq_data == line_data),
  .rxq_valid    (rxq_valid),
  .txq_valid    (txq_valid),
  .host_ready   (host_ready),
  .rx_rst_o     (rx_rst_o),
  .tx_rst_o     (tx_rst_o),
  .to_restart_o (to_restart_o),
  .brk_o        (brk_o)
);

// File: tb/sim_uart_ctl_router.sv
`timescale 1ns/1ps
module sim_uart_ctl_router;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic line_valid = 1'b0, host_valid = 1'b0;
  logic [DW-1:0] line_data = '0, host_data = '0;
  logic rxq_ready = 1'b1, txq_ready = 1'b1;
  logic line_ready, host_ready, rxq_valid, txq_valid;
  logic [DW-1:0] rxq_data, txq_data;
  logic rx_rst_o, tx_rst_o, to_restart_o, brk_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  uart_ctl_router #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .line_valid(line_valid), .line_data(line_data), .line_ready(line_ready),
    .host_valid(host_valid), .host_data(host_data), .host_ready(host_ready),
    .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_ready(rxq_ready),
    .txq_valid(txq_valid), .txq_data(txq_data), .txq_ready(txq_ready),
    .rx_rst_o(rx_rst_o), .tx_rst_o(tx_rst_o), .to_restart_o(to_restart_o), .brk_o(brk_o));

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // write at one edge; returns on the following falling edge
  task automatic cfg_write(input logic sel, input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic drive(input logic lv, input logic [7:0] ld, input logic hv, input logic [7:0] hd,
                       input logic rr, input logic tr);
    @(negedge clk);
    line_valid = lv; line_data = ld; host_valid = hv; host_data = hd;
    rxq_ready = rr; txq_ready = tr;
    #1;
  endtask

  task automatic t_reset;
    drive(1, 8'h42, 1, 8'h24, 1, 1);
    chk("R1", "rxq_valid", rxq_valid, 0);
    chk("R1", "txq_valid", txq_valid, 0);
    chk("R1", "line_ready", line_ready, 1);
    chk("R1", "host_ready", host_ready, 1);
    chk("R1", "brk_o", brk_o, 0);
    chk("R1", "strobes", {rx_rst_o, tx_rst_o, to_restart_o}, 0);
  endtask

  task automatic t_enables;
    cfg_write(0, 10'h00C);           // rx enable and disable both set
    drive(1, 8'h33, 0, 0, 1, 1);
    chk("R2", "rx disable wins", rxq_valid, 0);
    chk("R11", "dropped line ready", line_ready, 1);
    cfg_write(0, 10'h004);
    drive(1, 8'h33, 0, 0, 1, 1);
    chk("R2", "rx enabled", rxq_valid, 1);
    chk("R12", "rx data", rxq_data, 8'h33);
    cfg_write(0, 10'h030);           // tx enable and disable both set
    drive(0, 0, 1, 8'h66, 1, 1);
    chk("R2", "tx disable wins", txq_valid, 0);
    chk("R11", "dropped host ready", host_ready, 1);
    cfg_write(0, 10'h010);
    drive(0, 0, 1, 8'h66, 1, 1);
    chk("R2", "tx enabled", txq_valid, 1);
    chk("R11", "rx now off", rxq_valid, 0);
  endtask

  task automatic t_strobes;
    drive(0, 0, 0, 0, 1, 1);
    cfg_write(0, 10'h047);
    chk("R3", "rx_rst pulse", rx_rst_o, 1);
    chk("R3", "tx_rst pulse", tx_rst_o, 1);
    chk("R4", "timeout restart pulse", to_restart_o, 1);
    @(negedge clk); #1;
    chk("R3", "rx/tx rst cleared", {rx_rst_o, tx_rst_o}, 0);
    chk("R4", "restart cleared", to_restart_o, 0);
    drive(1, 8'h5C, 0, 0, 1, 1);
    chk("R2", "rx enable kept with strobes", rxq_valid, 1);
    cfg_write(0, 10'h004);
    chk("R3", "no pulse without bit", {rx_rst_o, tx_rst_o, to_restart_o}, 0);
  endtask

  task automatic t_break;
    cfg_write(0, 10'h094);
    chk("R5", "break on", brk_o, 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R5", "break held", brk_o, 1);
    cfg_write(0, 10'h194);
    chk("R5", "stop break wins", brk_o, 0);
    cfg_write(0, 10'h094);
    cfg_write(0, 10'h014);
    chk("R5", "break released", brk_o, 0);
  endtask

  task automatic t_normal;
    cfg_write(0, 10'h014);
    cfg_write(1, 10'h000);
    drive(1, 8'hA5, 1, 8'h3C, 1, 1);
    chk("R7", "line to rxq", {rxq_valid, rxq_data}, {1'b1, 8'hA5});
    chk("R7", "host to txq", {txq_valid, txq_data}, {1'b1, 8'h3C});
    drive(1, 8'hA5, 1, 8'h3C, 0, 1);
    chk("R12", "line stalls", line_ready, 0);
    chk("R12", "rxq valid held", rxq_valid, 1);
    drive(1, 8'hA5, 1, 8'h3C, 1, 0);
    chk("R12", "host stalls", host_ready, 0);
    chk("R12", "line flows", line_ready, 1);
  endtask

  task automatic t_echo;
    cfg_write(1, 10'h100);
    drive(1, 8'h5A, 0, 0, 1, 1);
    chk("R8", "echo rx", {rxq_valid, rxq_data}, {1'b1, 8'h5A});
    chk("R8", "echo tx", {txq_valid, txq_data}, {1'b1, 8'h5A});
    chk("R8", "echo accept", line_ready, 1);
    drive(1, 8'h5A, 0, 0, 1, 0);
    chk("R8", "rx held back by tx", rxq_valid, 0);
    chk("R8", "line stalls", line_ready, 0);
    drive(0, 0, 1, 8'h99, 1, 1);
    chk("R8", "host dropped", {rxq_valid, txq_valid, host_ready}, 3'b001);
  endtask

  task automatic t_local;
    cfg_write(1, 10'h200);
    drive(0, 0, 1, 8'h77, 1, 1);
    chk("R9", "host to rxq", {rxq_valid, rxq_data}, {1'b1, 8'h77});
    chk("R9", "no tx", txq_valid, 0);
    drive(1, 8'h12, 0, 0, 1, 1);
    chk("R9", "line dropped", {rxq_valid, txq_valid, line_ready}, 3'b001);
  endtask

  task automatic t_remote;
    cfg_write(1, 10'h300);
    drive(1, 8'h11, 0, 0, 1, 1);
    chk("R10", "line to txq", {txq_valid, txq_data}, {1'b1, 8'h11});
    chk("R10", "no rx", rxq_valid, 0);
    drive(0, 0, 1, 8'h22, 1, 1);
    chk("R10", "host dropped", {rxq_valid, txq_valid, host_ready}, 3'b001);
    chk("R6", "mode field decoded", txq_valid, 0);
  endtask

  task automatic t_same_cycle;
    drive(0, 0, 0, 0, 1, 1);
    cfg_write(1, 10'h000);
    cfg_write(0, 10'h014);
    @(negedge clk);
    line_valid = 1; line_data = 8'hC3;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 10'h01C;
    #1;
    chk("R13", "old enable in write cycle", rxq_valid, 1);
    @(negedge clk);
    cfg_we = 0;
    #1;
    chk("R13", "new disable after write", rxq_valid, 0);
    chk("R11", "dropped ready", line_ready, 1);
    line_valid = 0;
    host_valid = 1; host_data = 8'h4D;
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 10'h300;
    #1;
    chk("R13", "host routed by old mode", txq_valid, 1);
    @(negedge clk);
    cfg_we = 0;
    #1;
    chk("R13", "host dropped by new mode", {txq_valid, host_ready}, 2'b01);
    host_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_strobes();
    t_break();
    t_normal();
    t_echo();
    t_local();
    t_remote();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule